// File: doc/BRIEF.md
# Pixel Imaging-Mode Integration Accumulator

This block counts detector hits for each of 256 pixels over a repeating integration window and hands out one frame of counts per window. Each hit arrives as a one-clock strobe with a pixel index. A free-running microsecond timer closes a window after a programmable number of ticks. When a window closes, the filled counter bank is swapped out for draining and a freshly cleared bank takes over counting in the same clock. No hit is ever lost at a window boundary.

The drained frame leaves as a valid/ready stream of 256 words in ascending pixel order. A start-of-frame flag marks the first word, and the stream moves one word per clock while the consumer is ready. A mode input selects narrow (8-bit) or wide (16-bit) counts. Counts saturate instead of wrapping. If a frame is still draining when the next window closes, the new frame is discarded and a sticky flag records the loss.

Top module: `imaging_accum`

## Requirements
- R1: With `en` high, a window lasts exactly (`win_len_us`+1) microsecond ticks, where one tick is `TICK_DIV` clocks. Windows follow one another with no gap, and each window produces one frame.
- R2: Each frame is 256 words in ascending pixel order, pixel 0 first. `out_sof` is high on the first word only and is never high without `out_vld`.
- R3: A pixel's word equals the number of hits for that pixel sampled during its window. A hit on every enabled clock, including the clock that closes a window, is counted in exactly one frame (no dead time).
- R4: `wide_mode`=1 gives 16-bit counts that saturate at 65535. `wide_mode`=0 gives counts that saturate at 255, with `out_data[15:8]` zero. The depth of a frame is captured when its window closes.
- R5: While `out_vld` is high and `out_rdy` is low, `out_data` and `out_sof` hold. With `out_rdy` held high, the 256 words of a frame transfer on 256 consecutive clocks.
- R6: If the previous frame is still draining when a window closes, the new frame's counts are discarded and counting restarts from zero. `frame_lost` then goes high and stays high until `rst`.
- R7: While `en` is low, the window timer and both banks are cleared, the output stream is aborted (`out_vld` low), and hits are ignored.
- R8: After `rst`, `out_vld` and `frame_lost` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low clears timer and banks |
| wide_mode | input | 1 | 1 = 16-bit counts, 0 = 8-bit counts |
| win_len_us | input | 16 | Window length minus one, in microsecond ticks |
| hit_vld | input | 1 | Pixel hit strobe |
| hit_pix | input | 8 | Index of the hit pixel |
| out_rdy | input | 1 | Consumer ready |
| out_vld | output | 1 | Output word valid |
| out_data | output | 16 | Pixel count word |
| out_sof | output | 1 | First word of a frame |
| frame_lost | output | 1 | Sticky: a frame was dropped |

## Verification
A descending sparse hit pattern, with a different count per pixel, shows whether the words come out in pixel order and with the correct per-pixel count. A hit held on every clock across three windows tells the no-dead-time swap apart from a version that loses or double-counts boundary hits, and it also measures the window period. A 300-hit burst on one pixel separates the saturation at 255 from the full 16-bit count, and alternating ready shows the output holding under backpressure. Held backpressure across two window closes, and a mid-window disable, test frame dropping and clearing from the stream side alone.

// File: rtl/ia_pkg.sv
package ia_pkg;
  localparam int unsigned IA_CNT_W = 16;
  typedef logic [IA_CNT_W-1:0] cnt_t;
  localparam cnt_t IA_NARROW_MAX = cnt_t'(255);
  localparam cnt_t IA_WIDE_MAX   = '1;
endpackage

// File: rtl/ia_timer.sv
module ia_timer #(
  parameter int TICK_DIV = 100,
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        en,
  input  logic [15:0] win_len_us,
  output logic        win_end
);
  logic [PW-1:0] pre;
  logic [15:0]   us;
  logic          tick;

  assign tick    = en && (pre == PW'(TICK_DIV - 1));
  assign win_end = tick && (us == win_len_us);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      pre <= '0;
      us  <= '0;
    end else begin
      pre <= tick ? '0 : pre + 1'b1;
      if (tick) us <= win_end ? '0 : us + 1'b1;
    end
  end
endmodule

// File: rtl/ia_bank.sv
module ia_bank
  import ia_pkg::*;
#(
  parameter int NPIX = 256,
  localparam int IDX_W = $clog2(NPIX)
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             inc,
  input  logic [IDX_W-1:0] inc_idx,
  input  cnt_t             sat_max,
  input  logic [IDX_W-1:0] rd_idx,
  output cnt_t             rd_cnt
);
  cnt_t            mem [NPIX];
  logic [NPIX-1:0] live;
  cnt_t            cur;

  // an entry whose live bit is clear reads as zero: one-clock bank clear
  assign cur    = live[inc_idx] ? mem[inc_idx] : '0;
  assign rd_cnt = live[rd_idx] ? mem[rd_idx] : '0;

  always_ff @(posedge clk) begin
    if (inc && !clr) mem[inc_idx] <= (cur >= sat_max) ? sat_max : cur + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (clr)      live <= '0;
    else if (inc) live[inc_idx] <= 1'b1;
  end
endmodule

// File: rtl/ia_drain.sv
module ia_drain
  import ia_pkg::*;
#(
  parameter int NPIX = 256,
  localparam int IDX_W = $clog2(NPIX)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             start,
  input  logic             wide_in,
  input  cnt_t             rd_cnt,
  output logic [IDX_W-1:0] rd_idx,
  output logic             busy,
  output logic             frm_wide,
  input  logic             out_rdy,
  output logic             out_vld,
  output cnt_t             out_data,
  output logic             out_sof
);
  logic load;
  cnt_t clamped;

  assign load    = busy && (!out_vld || out_rdy);
  assign clamped = (!frm_wide && rd_cnt > IA_NARROW_MAX) ? IA_NARROW_MAX : rd_cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      busy     <= 1'b0;
      rd_idx   <= '0;
      frm_wide <= 1'b0;
      out_vld  <= 1'b0;
      out_sof  <= 1'b0;
      out_data <= '0;
    end else begin
      if (start) begin
        busy     <= 1'b1;
        rd_idx   <= '0;
        frm_wide <= wide_in;
      end else if (load) begin
        rd_idx <= rd_idx + 1'b1;
        if (rd_idx == IDX_W'(NPIX - 1)) busy <= 1'b0;
      end
      if (load) begin
        out_vld  <= 1'b1;
        out_data <= clamped;
        out_sof  <= (rd_idx == '0);
      end else if (out_rdy) begin
        out_vld <= 1'b0;
        out_sof <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/imaging_accum.sv
module imaging_accum
  import ia_pkg::*;
#(
  parameter int NPIX     = 256,
  parameter int TICK_DIV = 100,
  localparam int IDX_W = $clog2(NPIX)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             wide_mode,
  input  logic [15:0]      win_len_us,
  input  logic             hit_vld,
  input  logic [IDX_W-1:0] hit_pix,
  input  logic             out_rdy,
  output logic             out_vld,
  output logic [15:0]      out_data,
  output logic             out_sof,
  output logic             frame_lost
);
  logic             win_end, drn_busy, swap, drop, cnt_sel, frm_wide;
  logic [IDX_W-1:0] drn_idx;
  cnt_t             sat_max;
  cnt_t             rd_cnt [2];

  assign swap    = win_end && !drn_busy;
  assign drop    = win_end && drn_busy;
  assign sat_max = wide_mode ? IA_WIDE_MAX : IA_NARROW_MAX;

  ia_timer #(.TICK_DIV(TICK_DIV)) u_timer (
    .clk(clk), .rst(rst), .en(en), .win_len_us(win_len_us), .win_end(win_end)
  );

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic counting, clr_b, inc_b;
    assign counting = (cnt_sel == 1'(b));
    assign clr_b = rst || !en || (swap && !counting) || (drop && counting);
    assign inc_b = en && hit_vld && counting && !drop;
    ia_bank #(.NPIX(NPIX)) u_bank (
      .clk(clk), .clr(clr_b), .inc(inc_b), .inc_idx(hit_pix),
      .sat_max(sat_max), .rd_idx(drn_idx), .rd_cnt(rd_cnt[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || !en) cnt_sel <= 1'b0;
    else if (swap)  cnt_sel <= ~cnt_sel;
  end

  always_ff @(posedge clk) begin
    if (rst)       frame_lost <= 1'b0;
    else if (drop) frame_lost <= 1'b1;
  end

  ia_drain #(.NPIX(NPIX)) u_drain (
    .clk(clk), .rst(rst), .en(en), .start(swap), .wide_in(wide_mode),
    .rd_cnt(rd_cnt[~cnt_sel]), .rd_idx(drn_idx), .busy(drn_busy),
    .frm_wide(frm_wide), .out_rdy(out_rdy), .out_vld(out_vld),
    .out_data(out_data), .out_sof(out_sof)
  );
endmodule

// File: rtl/ia_accum_chk.sv
module ia_accum_chk (
  input logic        clk,
  input logic        rst,
  input logic        en,
  input logic        out_vld,
  input logic        out_rdy,
  input logic [15:0] out_data,
  input logic        out_sof,
  input logic        frame_lost,
  input logic        frm_wide
);
  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (en && out_vld && !out_rdy) |=> (out_vld && $stable(out_data) && $stable(out_sof)));

  // R7
  dis_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!out_vld && !out_sof));

  // R6
  lost_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    frame_lost |=> frame_lost);

  // R4
  narrow_chk: assert property (@(posedge clk) disable iff (rst)
    (out_vld && !frm_wide) |-> (out_data[15:8] == 8'h00));

  // R2
  sof_vld_chk: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_vld);

  // R8
  rst_state_chk: assert property (@(posedge clk)
    rst |=> (!out_vld && !frame_lost));
endmodule

bind imaging_accum ia_accum_chk u_chk (
  .clk(clk), .rst(rst), .en(en), .out_vld(out_vld), .out_rdy(out_rdy),
  .out_data(out_data), .out_sof(out_sof), .frame_lost(frame_lost),
  .frm_wide(frm_wide)
);

// File: tb/imaging_accum_tb.sv
module imaging_accum_tb;
  localparam int NPIX = 256;
  localparam int DIV  = 2;
  localparam int WLEN = 199;              // window = 200 ticks = 400 clocks
  localparam int NCLK = (WLEN + 1) * DIV;

  logic        clk = 1'b0;
  logic        rst, en, wide_mode, hit_vld, out_rdy;
  logic [15:0] win_len_us;
  logic [7:0]  hit_pix;
  logic        out_vld, out_sof, frame_lost;
  logic [15:0] out_data;

  int n_chk = 0, n_bad = 0, tcyc = 0;
  int got [NPIX];
  int first_t, last_t, sof_bad;

  always #5 clk = ~clk;
  always @(posedge clk) tcyc++;

  imaging_accum #(.NPIX(NPIX), .TICK_DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .en(en), .wide_mode(wide_mode), .win_len_us(win_len_us),
    .hit_vld(hit_vld), .hit_pix(hit_pix), .out_rdy(out_rdy), .out_vld(out_vld),
    .out_data(out_data), .out_sof(out_sof), .frame_lost(frame_lost)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reset_dut();
    rst = 1'b1; en = 1'b0; hit_vld = 1'b0; hit_pix = '0; out_rdy = 1'b0;
    wide_mode = 1'b1; win_len_us = 16'(WLEN);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic hit_n(input int pix, input int n);
    for (int i = 0; i < n; i++) begin
      hit_vld = 1'b1; hit_pix = 8'(pix);
      @(negedge clk);
    end
    hit_vld = 1'b0;
  endtask

  // mode 0: ready always; mode 1: ready on alternate clocks
  task automatic collect(input int mode);
    int n = 0, c = 0;
    sof_bad = 0;
    while (n < NPIX) begin
      @(negedge clk);
      c++;
      out_rdy = (mode == 0) ? 1'b1 : c[0];
      if (out_vld && out_rdy && (n > 0 || out_sof)) begin
        if (n > 0 && out_sof) sof_bad++;
        if (n == 0) first_t = tcyc;
        if (n == NPIX - 1) last_t = tcyc;
        got[n] = int'(out_data);
        n++;
      end
    end
  endtask

  task automatic t_reset();
    reset_dut();
    chk("R8 out_vld after reset", int'(out_vld), 0);
    chk("R8 frame_lost after reset", int'(frame_lost), 0);
  endtask

  task automatic t_pattern();
    int bad = 0;
    reset_dut();
    en = 1'b1;
    for (int p = NPIX - 1; p >= 0; p--) hit_n(p, p % 3);
    collect(0);
    out_rdy = 1'b0;
    for (int p = 0; p < NPIX; p++) if (got[p] != p % 3) begin
      bad++;
      chk("R3 pattern pixel count", got[p], p % 3);
    end
    chk("R3 pattern mismatching pixels", bad, 0);
    chk("R2 sof only on first word", sof_bad, 0);
    chk("R5 256 words on consecutive clocks", last_t - first_t, NPIX - 1);
  endtask

  task automatic t_depth(input logic wide);
    int hi = 0;
    reset_dut();
    wide_mode = wide; en = 1'b1;
    hit_n(7, 300);
    hit_n(8, 3);
    collect(1);
    out_rdy = 1'b0;
    for (int p = 0; p < NPIX; p++) if (got[p] > 255) hi++;
    chk("R4 pixel7 after 300 hits", got[7], wide ? 300 : 255);
    chk("R5 pixel8 under alternating ready", got[8], 3);
    chk("R5 pixel9 untouched", got[9], 0);
    if (!wide) chk("R4 narrow upper byte zero", hi, 0);
  endtask

  task automatic t_deadtime();
    int t [3];
    reset_dut();
    en = 1'b1; hit_vld = 1'b1; hit_pix = 8'd3;
    for (int f = 0; f < 3; f++) begin
      collect(0);
      t[f] = first_t;
      chk("R3 every-clock hits per window", got[3], NCLK);
      chk("R3 neighbour pixel zero", got[4], 0);
    end
    hit_vld = 1'b0; out_rdy = 1'b0;
    chk("R1 frame period 1->2", t[1] - t[0], NCLK);
    chk("R1 frame period 2->3", t[2] - t[1], NCLK);
  endtask

  task automatic t_overflow();
    reset_dut();
    en = 1'b1;
    repeat (10) @(negedge clk);
    hit_n(10, 5);                    // window 1
    repeat (480) @(negedge clk);
    chk("R6 no loss while window 2 open", int'(frame_lost), 0);
    hit_n(20, 3);                    // window 2, to be dropped
    repeat (350) @(negedge clk);
    chk("R6 frame_lost after blocked close", int'(frame_lost), 1);
    hit_n(30, 2);                    // window 3
    collect(0);
    chk("R6 held frame pixel10", got[10], 5);
    chk("R6 held frame pixel20", got[20], 0);
    collect(0);
    out_rdy = 1'b0;
    chk("R6 next frame pixel30", got[30], 2);
    chk("R6 dropped counts discarded", got[20], 0);
    chk("R6 frame_lost stays set", int'(frame_lost), 1);
  endtask

  task automatic t_disable();
    int seen = 0;
    reset_dut();
    en = 1'b1;
    hit_n(50, 4);
    repeat (50) @(negedge clk);
    en = 1'b0;
    hit_n(60, 6);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (out_vld) seen++;
    end
    chk("R7 no output while disabled", seen, 0);
    en = 1'b1;
    hit_n(70, 1);
    collect(0);
    out_rdy = 1'b0;
    chk("R7 pre-disable hits cleared", got[50], 0);
    chk("R7 hits while disabled ignored", got[60], 0);
    chk("R7 hit after re-enable", got[70], 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_pattern();
    t_depth(1'b0);
    t_depth(1'b1);
    t_deadtime();
    t_overflow();
    t_disable();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule